// File: doc/BRIEF.md
# Programmable System Clock Prescaler

This block turns a free-running oscillator clock into the slower rate used by a processor core and its peripherals. An 8-bit reload value selects an even division ratio between 2 and 512, following ratio = 512 - 2 x reload. Inside the oscillator domain, a counter toggles a divided clock at every half period, so the divided clock has a 50% duty cycle. A one-cycle tick marks each rising edge of the divided clock, and downstream logic uses it as a clock enable.

Software may rewrite the reload value at any time. A new value only takes effect at the next half-period boundary, so the divided clock never produces a shortened pulse. When the double-speed input is held high, division is bypassed. In that mode the tick is asserted on every oscillator cycle, the divided clock stays high, and the stored reload value is ignored until the input falls again.

Top module: `sysclk_prescaler`

## Requirements
- R1: While `rst_ni` is low, `div_clk_o` and `tick_o` are 0. Reset sets the reload value to 8'hFF, so after reset the prescaler divides by 2 with no write needed.
- R2: In divide mode, consecutive `tick_o` pulses are exactly 512 - 2 x reload oscillator cycles apart.
- R3: In divide mode, each high phase of `div_clk_o` lasts exactly 256 - reload oscillator cycles.
- R4: `tick_o` is high for a single oscillator cycle, in the cycle in which `div_clk_o` first reads high after being low. `tick_o` is never high while `div_clk_o` is low.
- R5: A write (`ld_we_i` high at a rising edge) stores `ld_val_i` as the new reload value. Only half phases that begin after that edge use the new value, so a half phase already running keeps its old length.
- R6: With `dbl_i` high at a rising edge, both `tick_o` and `div_clk_o` read 1 after that edge. The reload value has no effect on the outputs in this mode. A value written in this mode is kept and used once `dbl_i` returns low.
- R7: The full reload range gives the expected ratios: 8'h00 gives 512, 8'hFE gives 4, and 8'hFF gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ld_we_i | input | 1 | Reload write strobe |
| ld_val_i | input | 8 | Reload value to store |
| dbl_i | input | 1 | Double-speed request, bypasses division |
| div_clk_o | output | 1 | Divided clock, 50% duty cycle |
| tick_o | output | 1 | One-cycle enable at each divided-clock rising edge |

## Verification
The properties assume that `dbl_i` and `ld_we_i` are synchronous to `clk_i` and settle before each rising edge. They also assume that the tick-spacing rules hold only while `dbl_i` stays low. The stimulus drives every input at the falling edge of the clock. It measures tick spacing and high-phase length only after three ticks have passed since the last reload write or mode change. The one deliberate write in the middle of a phase is timed against a known tick, so its expected phase lengths are exact.

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_we_i,
  input  logic [RW-1:0] ld_val_i,
  input  logic          dbl_i,
  output logic          div_clk_o,
  output logic          tick_o
);
  localparam logic [RW-1:0] RST_VAL = {RW{1'b1}};

  logic [RW-1:0] reload_q;
  logic [RW-1:0] cnt_q;
  logic          div_q;
  logic          tick_q;
  logic          edge_w;

  assign edge_w    = (cnt_q == '0);
  assign div_clk_o = div_q;
  assign tick_o    = tick_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      reload_q <= RST_VAL;
    else if (ld_we_i) reload_q <= ld_val_i;
  end

  // half phase length is 2^RW - reload, so the count-down start is ~reload
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (dbl_i) begin
      cnt_q  <= '0;
      div_q  <= 1'b1;
      tick_q <= 1'b1;
    end else if (edge_w) begin
      cnt_q  <= ~reload_q;
      div_q  <= ~div_q;
      tick_q <= ~div_q;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sysclk_prescaler_chk.sv
module sysclk_prescaler_chk #(
  parameter int RW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ld_we_i,
  input logic          dbl_i,
  input logic          div_clk_o,
  input logic          tick_o,
  input logic [RW-1:0] reload_q
);
  // R4
  tick_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> div_clk_o);

  // R4
  rise_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_clk_o) |-> tick_o);

  // R4
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !dbl_i) |=> !tick_o);

  // R6
  dbl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_i |=> (tick_o && div_clk_o));

  // R5
  reload_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_we_i |=> $stable(reload_q));
endmodule

bind sysclk_prescaler sysclk_prescaler_chk #(.RW(RW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld_we_i(ld_we_i), .dbl_i(dbl_i),
  .div_clk_o(div_clk_o), .tick_o(tick_o), .reload_q(reload_q)
);

// File: tb/sysclk_prescaler_tb.sv
`timescale 1ns/1ps
module sysclk_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] val = 8'h00;
  logic       dbl = 1'b0;
  logic       div_clk, tick;

  int vectors = 0, miscompares = 0;
  int cyc = 0, last_tick = 0, hi_run = 0, hi_len = 0;
  bit armed = 1'b0, done = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  sysclk_prescaler u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ld_we_i(we), .ld_val_i(val),
    .dbl_i(dbl), .div_clk_o(div_clk), .tick_o(tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops the expected half length at each tick
  always @(negedge clk) begin
    cyc++;
    if (div_clk) hi_run++;
    else if (hi_run != 0) begin hi_len = hi_run; hi_run = 0; end
    if (tick) begin
      if (armed && exp_q.size() != 0) begin
        int h;
        h = exp_q.pop_front();
        check(cyc - last_tick == 2*h, "R2 tick spacing", cyc - last_tick, 2*h);
        check(hi_len == h, "R3 high phase", hi_len, h);
      end
      last_tick = cyc;
    end
  end

  task automatic write_reload(input logic [7:0] r);
    @(negedge clk); we = 1'b1; val = r;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
    end
  endtask

  task automatic run_cfg(input logic [7:0] r, input bit do_write, input int n);
    armed = 1'b0;
    if (do_write) write_reload(r);
    wait_ticks(3);
    #1;
    for (int i = 0; i < n; i++) exp_q.push_back(256 - int'(r));
    armed = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    armed = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int k, l;
    repeat (4) @(negedge clk);
    // R1 outputs low in reset
    check(div_clk == 1'b0, "R1 div_clk in reset", div_clk, 0);
    check(tick == 1'b0, "R1 tick in reset", tick, 0);
    rst_n = 1'b1;
    // R1 default reload FF: divide by 2
    run_cfg(8'hFF, 1'b0, 6);
    // R7 FE gives divide by 4
    run_cfg(8'hFE, 1'b1, 6);
    // R7 00 gives divide by 512
    run_cfg(8'h00, 1'b1, 3);
    run_cfg(8'hA5, 1'b1, 4);
    run_cfg(8'h80, 1'b1, 3);
    run_cfg(8'hF0, 1'b1, 4);

    // R5: write in mid high phase (half length 16), new value FE applies afterwards
    wait_ticks(1);
    k = 1;
    forever begin
      if (k == 4) begin we = 1'b1; val = 8'hFE; end
      @(negedge clk);
      we = 1'b0;
      if (div_clk) k++; else break;
    end
    check(k == 16, "R5 running high phase kept", k, 16);
    l = 1;
    forever begin
      @(negedge clk);
      if (!div_clk) l++; else break;
    end
    check(l == 2, "R5 next low phase uses new value", l, 2);
    check(tick == 1'b1, "R4 tick at rise after change", tick, 1);
    run_cfg(8'hFE, 1'b0, 3);

    // R6 double speed bypass, write during bypass ignored then retained
    @(negedge clk); dbl = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      if (i == 5) begin we = 1'b1; val = 8'hF0; end
      if (i == 6) we = 1'b0;
      check(tick == 1'b1 && div_clk == 1'b1, "R6 bypass outputs", {tick, div_clk}, 3);
      @(negedge clk);
    end
    dbl = 1'b0;
    run_cfg(8'hF0, 1'b0, 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule